// File: doc/BRIEF.md
# Reservation Unit for Load-Reserved / Store-Conditional

This block carries out the two halves of an atomic read-modify-write pair for a 64-bit core. A load-reserved reads a word or a doubleword, returns it for the destination register and records a reservation on the virtual address it used. A later store-conditional to the same address writes to memory only while that reservation is still held. It reports through the destination write whether the store happened (0) or not (1). A successful store drops the reservation.

The core presents one decoded operation at a time on a start strobe: kind, width, the acquire/release flags, the destination index and the two source register values. A translation-fault flag comes with the operation. Address translation is otherwise identity. The unit issues at most one request on a simple memory port and waits for a response that carries either data or an error. It finishes with a one-cycle done pulse. That pulse comes with either a register write or an exception (cause and faulting address).

Checks run in a fixed order. Width legality comes first, then alignment. For a store-conditional, the reservation check comes next and happens before any translation or memory traffic. The acquire/release flags are passed to the memory port unchanged.

Top module: `lrsc_unit`

## Requirements
- R1: After reset no reservation is held, and `done_o`, `mem_req_o` and `busy_o` are low.
- R2: The width codes are 0 byte, 1 halfword, 2 word and 3 doubleword. Byte and halfword widths raise cause 2 (illegal instruction) with `tval_o` equal to the address. They make no memory request and no register write.
- R3: A word operation needs address bits 1:0 clear, and a doubleword operation needs bits 2:0 clear. A misaligned address raises cause 6 with `tval_o` equal to the address. It makes no memory request, no register write and no change to the reservation.
- R4: A load-reserved (`kind_i`=0) that succeeds reads 4 bytes (`mem_size8_o`=0) or 8 bytes (`mem_size8_o`=1). It writes the register with the data, sign-extending from bit 31 for a word. It records a reservation on the address.
- R5: A load-reserved with a translation fault (no memory request) or a memory error raises cause 5 with the address in `tval_o`. It writes no register and leaves the reservation unchanged.
- R6: A store-conditional (`kind_i`=1) whose address differs from the held reservation, or that finds none held, writes 1 to the register. It completes on the cycle after start with no memory request and no exception.
- R7: A store-conditional whose address matches the reservation writes the low 32 bits of rs2 (upper bits zero) for a word, or all 64 bits for a doubleword. When the write completes it writes 0 to the register and clears the reservation.
- R8: A matching store-conditional that meets a translation fault (no memory request) or a memory write error raises cause 7. It writes no register and keeps the reservation.
- R9: Only one operation is in flight. `start_i` is ignored while `busy_o` is high. `done_o` is a one-cycle pulse with exactly one of `rd_we_o` and `exc_o` asserted.
- R10: A new load-reserved replaces any earlier reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start an operation (taken when not busy) |
| kind_i | input | 1 | 0 load-reserved, 1 store-conditional |
| width_i | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| aq_i | input | 1 | Acquire flag, passed through |
| rl_i | input | 1 | Release flag, passed through |
| rd_idx_i | input | RIDX_W | Destination register index |
| rs1_val_i | input | XLEN | Virtual address |
| rs2_val_i | input | XLEN | Store data |
| xlat_fault_i | input | 1 | Translation failed for this operation |
| busy_o | output | 1 | Waiting on memory |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_size8_o | output | 1 | 8-byte access (else 4) |
| mem_aq_o | output | 1 | Acquire flag to memory |
| mem_rl_o | output | 1 | Release flag to memory |
| mem_addr_o | output | XLEN | Access address |
| mem_wdata_o | output | XLEN | Write data |
| mem_rsp_i | input | 1 | Memory response valid |
| mem_err_i | input | 1 | Response is an error |
| mem_rdata_i | input | XLEN | Read data |
| done_o | output | 1 | Operation finished (one cycle) |
| rd_we_o | output | 1 | Register write enable |
| rd_idx_o | output | RIDX_W | Register index |
| rd_data_o | output | XLEN | Register write value |
| exc_o | output | 1 | Exception raised |
| exc_cause_o | output | 4 | Exception cause code |
| tval_o | output | XLEN | Faulting virtual address |

## Verification
Some properties are checked on every cycle. Each done pulse must carry exactly one outcome. Busy must begin with a memory request. An illegal or misaligned start must end the next cycle in the right exception with no request. A store-conditional that finds no reservation must report 1 without touching memory. A successful store must leave no reservation behind. Only the bench's scenarios can show that a reservation survives faults and misaligned attempts, that a newer load replaces an older reservation, and that reset drops it. The same holds for the exact data placed on the memory port and in the register, and for a start ignored while the unit waits on memory.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [1:0] {
    W_BYTE   = 2'd0,
    W_HALF   = 2'd1,
    W_WORD   = 2'd2,
    W_DOUBLE = 2'd3
  } width_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL   = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN  = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT  = 4'd7;
endpackage

// File: rtl/lrsc_align.sv
module lrsc_align
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] addr_i,
  input  logic [1:0]      width_i,
  output logic            legal_o,
  output logic            aligned_o
);
  localparam int LSB_W = 3;
  logic [LSB_W-1:0] mask;

  always_comb begin
    unique case (width_i)
      W_BYTE:   mask = 3'b000;
      W_HALF:   mask = 3'b001;
      W_WORD:   mask = 3'b011;
      default:  mask = 3'b111;
    endcase
    aligned_o = (addr_i[LSB_W-1:0] & mask) == '0;
    legal_o   = width_i[1];
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic [AW-1:0] probe_addr_i,
  output logic          valid_o,
  output logic          hit_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_q  <= set_addr_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  assign hit_o = valid_o && (addr_q == probe_addr_i);
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                kind_i,
  input  logic [1:0]          width_i,
  input  logic                aq_i,
  input  logic                rl_i,
  input  logic [RIDX_W-1:0]   rd_idx_i,
  input  logic [XLEN-1:0]     rs1_val_i,
  input  logic [XLEN-1:0]     rs2_val_i,
  input  logic                xlat_fault_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic                mem_size8_o,
  output logic                mem_aq_o,
  output logic                mem_rl_o,
  output logic [XLEN-1:0]     mem_addr_o,
  output logic [XLEN-1:0]     mem_wdata_o,
  input  logic                mem_rsp_i,
  input  logic                mem_err_i,
  input  logic [XLEN-1:0]     mem_rdata_i,
  output logic                done_o,
  output logic                rd_we_o,
  output logic [RIDX_W-1:0]   rd_idx_o,
  output logic [XLEN-1:0]     rd_data_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o,
  output logic [XLEN-1:0]     tval_o
);
  localparam int HALF_W = XLEN / 2;

  state_e            state_q;
  logic              op_sc;
  logic              op_dbl;
  logic [XLEN-1:0]   op_va;
  logic              legal, aligned;
  logic              resv_valid, resv_hit;
  logic              rsp_ok, resv_set, resv_clr;
  logic [XLEN-1:0]   load_val;

  lrsc_align #(.XLEN(XLEN)) u_align (
    .addr_i    (rs1_val_i),
    .width_i   (width_i),
    .legal_o   (legal),
    .aligned_o (aligned)
  );

  assign rsp_ok   = (state_q == ST_WAIT) && mem_rsp_i && !mem_err_i;
  assign resv_set = rsp_ok && !op_sc;
  assign resv_clr = rsp_ok && op_sc;

  lrsc_resv #(.AW(XLEN)) u_resv (
    .clk          (clk),
    .rst          (rst),
    .set_i        (resv_set),
    .clr_i        (resv_clr),
    .set_addr_i   (op_va),
    .probe_addr_i (rs1_val_i),
    .valid_o      (resv_valid),
    .hit_o        (resv_hit)
  );

  assign load_val = op_dbl ? mem_rdata_i
                           : {{HALF_W{mem_rdata_i[HALF_W-1]}}, mem_rdata_i[HALF_W-1:0]};
  assign busy_o   = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_sc       <= 1'b0;
      op_dbl      <= 1'b0;
      op_va       <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_size8_o <= 1'b0;
      mem_aq_o    <= 1'b0;
      mem_rl_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
      exc_o       <= 1'b0;
      exc_cause_o <= '0;
      tval_o      <= '0;
    end else begin
      done_o    <= 1'b0;
      rd_we_o   <= 1'b0;
      exc_o     <= 1'b0;
      mem_req_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_sc    <= kind_i;
            op_dbl   <= (width_i == W_DOUBLE);
            op_va    <= rs1_val_i;
            rd_idx_o <= rd_idx_i;
            tval_o   <= rs1_val_i;
            if (!legal) begin
              done_o      <= 1'b1;
              exc_o       <= 1'b1;
              exc_cause_o <= CAUSE_ILLEGAL;
            end else if (!aligned) begin
              done_o      <= 1'b1;
              exc_o       <= 1'b1;
              exc_cause_o <= CAUSE_MISALIGN;
            end else if (kind_i && !resv_hit) begin
              done_o    <= 1'b1;
              rd_we_o   <= 1'b1;
              rd_data_o <= XLEN'(1);
            end else if (xlat_fault_i) begin
              done_o      <= 1'b1;
              exc_o       <= 1'b1;
              exc_cause_o <= kind_i ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
            end else begin
              mem_req_o   <= 1'b1;
              mem_we_o    <= kind_i;
              mem_size8_o <= (width_i == W_DOUBLE);
              mem_aq_o    <= aq_i;
              mem_rl_o    <= rl_i;
              mem_addr_o  <= rs1_val_i;
              mem_wdata_o <= (width_i == W_DOUBLE) ? rs2_val_i
                                                   : {{HALF_W{1'b0}}, rs2_val_i[HALF_W-1:0]};
              state_q     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_i) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            if (mem_err_i) begin
              exc_o       <= 1'b1;
              exc_cause_o <= op_sc ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
            end else begin
              rd_we_o   <= 1'b1;
              rd_data_o <= op_sc ? '0 : load_val;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            kind_i,
  input logic [1:0]      width_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            done_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] rd_data_o,
  input logic            exc_o,
  input logic [3:0]      exc_cause_o,
  input logic            resv_valid,
  input logic            op_sc
);
  logic take, fits;
  assign take = start_i && !busy_o;
  assign fits = (width_i == 2'd2) ? (rs1_val_i[1:0] == 2'b00) : (rs1_val_i[2:0] == 3'b000);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rd_we_o != exc_o));

  p_busy_starts_with_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> mem_req_o);

  p_narrow_illegal_r2: assert property (@(posedge clk) disable iff (rst)
    (take && !width_i[1]) |=> (done_o && exc_o && exc_cause_o == 4'd2 && !mem_req_o));

  p_misalign_r3: assert property (@(posedge clk) disable iff (rst)
    (take && width_i[1] && !fits) |=> (done_o && exc_o && exc_cause_o == 4'd6 && !mem_req_o));

  p_sc_no_resv_r6: assert property (@(posedge clk) disable iff (rst)
    (take && kind_i && width_i[1] && fits && !resv_valid)
      |=> (done_o && rd_we_o && rd_data_o == XLEN'(1) && !mem_req_o));

  p_sc_success_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && rd_we_o && op_sc && rd_data_o == '0) |-> !resv_valid);
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .kind_i      (kind_i),
  .width_i     (width_i),
  .rs1_val_i   (rs1_val_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .done_o      (done_o),
  .rd_we_o     (rd_we_o),
  .rd_data_o   (rd_data_o),
  .exc_o       (exc_o),
  .exc_cause_o (exc_cause_o),
  .resv_valid  (resv_valid),
  .op_sc       (op_sc)
);

// File: tb/lrsc_unit_tb.sv
module lrsc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam logic [63:0] MEMDATA = 64'h1122_3344_8765_4321;

  typedef struct packed {
    logic        kind;
    logic [1:0]  width;
    logic [63:0] addr;
    logic [63:0] wdata;
    logic        xf;
    logic        merr;
    logic        exp_mem;
    logic        exp_exc;
    logic [3:0]  exp_cause;
    logic [63:0] exp_rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 64'h100, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1},                                     // R6 none held
    '{1'b0, 2'd2, 64'h100, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'hFFFF_FFFF_8765_4321},                   // R4 word sext
    '{1'b1, 2'd2, 64'h104, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1},                                     // R6 mismatch
    '{1'b1, 2'd2, 64'h100, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},                   // R7 word
    '{1'b1, 2'd2, 64'h100, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1},                                     // R7 cleared
    '{1'b0, 2'd3, 64'h208, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, MEMDATA},                                   // R4 dword
    '{1'b0, 2'd3, 64'h20C, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 64'h0},                                     // R3 dword
    '{1'b1, 2'd3, 64'h208, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 64'h0},                                     // R8 xlat
    '{1'b1, 2'd3, 64'h208, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 64'h0},                                     // R8 mem err
    '{1'b1, 2'd3, 64'h208, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},                   // R7 dword
    '{1'b0, 2'd1, 64'h300, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 64'h0},                                     // R2 half
    '{1'b1, 2'd0, 64'h301, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 64'h0},                                     // R2 byte
    '{1'b0, 2'd2, 64'h402, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 64'h0},                                     // R3 word
    '{1'b0, 2'd2, 64'h400, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5, 64'h0},                                     // R5 xlat
    '{1'b0, 2'd2, 64'h400, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5, 64'h0},                                     // R5 mem err
    '{1'b1, 2'd2, 64'h400, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1},                                     // R5 no resv set
    '{1'b0, 2'd2, 64'h500, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'hFFFF_FFFF_8765_4321},                   // R10 first
    '{1'b0, 2'd3, 64'h600, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, MEMDATA},                                   // R10 second
    '{1'b1, 2'd2, 64'h500, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1},                                     // R10 old lost
    '{1'b1, 2'd3, 64'h600, 64'h5555_AAAA_0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0}                    // R10 new held
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, kind_i = 0, aq_i = 0, rl_i = 0, xlat_fault_i = 0;
  logic [1:0] width_i = 0;
  logic [4:0] rd_idx_i = 0;
  logic [63:0] rs1_val_i = 0, rs2_val_i = 0, mem_rdata_i = 0;
  logic mem_rsp_i = 0, mem_err_i = 0;
  logic busy_o, mem_req_o, mem_we_o, mem_size8_o, mem_aq_o, mem_rl_o;
  logic [63:0] mem_addr_o, mem_wdata_o, rd_data_o, tval_o;
  logic done_o, rd_we_o, exc_o;
  logic [4:0] rd_idx_o;
  logic [3:0] exc_cause_o;

  int n_checks = 0, n_fail = 0;
  logic run_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_unit #(.XLEN(XLEN), .RIDX_W(5)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .width_i(width_i),
    .aq_i(aq_i), .rl_i(rl_i), .rd_idx_i(rd_idx_i), .rs1_val_i(rs1_val_i),
    .rs2_val_i(rs2_val_i), .xlat_fault_i(xlat_fault_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size8_o(mem_size8_o),
    .mem_aq_o(mem_aq_o), .mem_rl_o(mem_rl_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rsp_i(mem_rsp_i), .mem_err_i(mem_err_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .rd_we_o(rd_we_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .exc_o(exc_o),
    .exc_cause_o(exc_cause_o), .tval_o(tval_o)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one operation, answer a memory request at once, return the outcome.
  task automatic run_op(input vec_t v, input string req);
    logic saw_mem = 1'b0;
    logic got_done = 1'b0;
    @(negedge clk);
    start_i = 1; kind_i = v.kind; width_i = v.width; rs1_val_i = v.addr;
    rs2_val_i = v.wdata; xlat_fault_i = v.xf; rd_idx_i = 5'd9; aq_i = 1; rl_i = 0;
    for (int i = 0; i < 20 && !got_done; i++) begin
      @(negedge clk);
      start_i = 0; mem_rsp_i = 0; mem_err_i = 0;
      if (mem_req_o) begin
        saw_mem = 1'b1;
        check(req, "mem we", 64'(mem_we_o), 64'(v.kind));
        check(req, "mem size8", 64'(mem_size8_o), 64'(v.width == 2'd3));
        check(req, "mem addr", mem_addr_o, v.addr);
        if (v.kind)
          check(req, "mem wdata", mem_wdata_o,
                (v.width == 2'd3) ? v.wdata : {32'h0, v.wdata[31:0]});
        mem_rsp_i = 1; mem_err_i = v.merr; mem_rdata_i = MEMDATA;
      end else if (done_o) begin
        got_done = 1'b1;
        check(req, "exc", 64'(exc_o), 64'(v.exp_exc));
        check(req, "rd_we", 64'(rd_we_o), 64'(!v.exp_exc));
        if (v.exp_exc) begin
          check(req, "cause", 64'(exc_cause_o), 64'(v.exp_cause));
          check(req, "tval", tval_o, v.addr);
        end else begin
          check(req, "rd data", rd_data_o, v.exp_rd);
        end
      end
    end
    mem_rsp_i = 0; mem_err_i = 0;
    check(req, "done seen", 64'(got_done), 64'b1);
    check(req, "mem access", 64'(saw_mem), 64'(v.exp_mem));
    @(negedge clk);
    check("R9", "done one cycle", 64'(done_o), 64'b0);
  endtask

  initial begin
    vec_t t;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", "done after reset", 64'(done_o), 64'b0);
    check("R1", "mem_req after reset", 64'(mem_req_o), 64'b0);
    check("R1", "busy after reset", 64'(busy_o), 64'b0);

    for (int k = 0; k < NV; k++) run_op(VECS[k], $sformatf("vec%0d", k));

    // R9: start while busy is ignored
    @(negedge clk);
    start_i = 1; kind_i = 0; width_i = 2'd2; rs1_val_i = 64'h700; xlat_fault_i = 0;
    @(negedge clk);
    check("R9", "req for LR", 64'(mem_req_o), 64'b1);
    start_i = 1; kind_i = 1; rs1_val_i = 64'h900;
    @(negedge clk);
    check("R9", "busy held", 64'(busy_o), 64'b1);
    check("R9", "no done while busy", 64'(done_o), 64'b0);
    check("R9", "no second req", 64'(mem_req_o), 64'b0);
    start_i = 0; mem_rsp_i = 1; mem_rdata_i = MEMDATA;
    @(negedge clk);
    mem_rsp_i = 0;
    check("R9", "done after rsp", 64'(done_o & rd_we_o), 64'b1);
    check("R9", "LR data kept", rd_data_o, 64'hFFFF_FFFF_8765_4321);
    @(negedge clk);
    check("R9", "no extra done", 64'(done_o), 64'b0);
    t = '{1'b1, 2'd2, 64'h700, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0};
    run_op(t, "R9 resv from first op");

    // R1: reset drops the reservation
    t = '{1'b0, 2'd2, 64'h800, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'hFFFF_FFFF_8765_4321};
    run_op(t, "R1 LR before reset");
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    t = '{1'b1, 2'd2, 64'h800, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h1};
    run_op(t, "R1 SC after reset");

    run_done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !run_done; c++) @(posedge clk);
    if (!run_done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule